// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-mapped master for the two-wire management bus (MDC clock, bidirectional MDIO data). Software builds the complete 32-bit frame image in one word: start marker, read or write opcode, device and register fields, turnaround marker and, for writes, the 16-bit payload. Writing that word to the data register sends it on the wire, most significant bit first. A preamble of 32 ones may go before it. For a read frame the controller releases MDIO for the turnaround and data bits and shifts in the 16 bits the PHY returns. Software then reads them from the low half of the data register.

The control register holds a preamble enable, the MDC divisor and a sticky completion flag. The flag clears when a frame is launched and sets when the last bit has been sent. A divisor of zero disables the controller, so software writes 0 to the control register after each access. Selecting a PHY page needs no special hardware. Software sends an ordinary write frame to register address 0x1F with the PHY number placed at bit 4 and above in the payload.

The sequencer has three states. ST_IDLE goes to ST_PREAMBLE on a launch when the preamble is enabled, and to ST_FRAME on a launch when it is not. ST_PREAMBLE goes to ST_FRAME on the falling MDC edge that ends its 32nd bit. ST_FRAME goes back to ST_IDLE on the falling MDC edge that ends frame bit 0, which also sets the completion flag. In every other case each state holds.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, MDC, MDIO output and MDIO output-enable are low, and both the control register (offset 0x128) and the data register (offset 0x12C) read 0.
- R2: The control register reads the divisor in bits 6:0, the preamble enable in bit 7 and the completion flag in bit 8. All other bits read 0, and writing them has no effect.
- R3: A write to the data register while the controller is idle and the divisor is nonzero launches a frame. The completion flag reads 0 from the next cycle on.
- R4: While a frame runs, MDC stays high for exactly divisor+1 clocks and low for exactly divisor+1 clocks. When idle, MDC is low.
- R5: With bit 7 set, 32 ones are driven with output-enable high before the frame. With bit 7 clear, no preamble is sent.
- R6: The frame sends data word bits 31 down to 0, one per MDC period. MDIO output changes only on falling MDC edges, so it is stable when MDC rises.
- R7: When bit 29 of the word is set (read), output-enable is low for frame bits 17 down to 0. Otherwise output-enable stays high for the whole frame.
- R8: For a read, MDIO input is sampled on the rising MDC edges of frame bits 15 down to 0 (first sample is bit 15). After completion the data register reads the written word with its low 16 bits replaced by the sampled value.
- R9: The completion flag sets exactly 2·(divisor+1)·N clocks after the launching write, where N is 32, or 64 with the preamble.
- R10: A data-register write while a frame is running is ignored. The running frame and the data register keep the first word.
- R11: With divisor 0, a data-register write is ignored: no MDC edge, and the completion flag and data register keep their values.
- R12: A PHY-select frame (write opcode, register address 0x1F at bits 22:18, PHY number at bits 8:4) is sent bit-exact like any write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output-enable |

## Verification
The hardest case to reach is a read frame whose returned bits line up with the correct rising MDC edges. The PHY must present each bit before an edge the bench cannot see in advance. To get there, the bench acts as the PHY. It counts MDC rising edges and, on every falling edge it sees, places the next expected data bit on MDIO. The edge count is derived from the preamble setting, and the value changes for each divisor and preamble combination, so any off-by-one in sampling shows up as a wrong read value. A second write is also injected partway through a frame to exercise the busy path.

// File: rtl/mdio_fc_pkg.sv
package mdio_fc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_FRAME    = 2'd2
    } mdio_state_e;

    localparam int FRAME_W  = 32;
    localparam int DATA_W   = 16;
    localparam int TA_HI    = 17;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int RD_BIT   = 29;
endpackage

// File: rtl/mdio_fc_clkgen.sv
module mdio_fc_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             hit;

    assign hit  = run && (cnt == div);
    assign rise = hit && !mdc;
    assign fall = hit && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (hit) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_fc_engine.sv
module mdio_fc_engine
    import mdio_fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [FRAME_W-1:0] word,
    input  logic              pre_en,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              in_pre,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              result_rd
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_HI);
    localparam logic [CNT_W-1:0] DATA_TOP = CNT_W'(DATA_W - 1);

    mdio_state_e          state, nxt;
    logic [CNT_W-1:0]     bit_cnt;
    logic [FRAME_W-1:0]   shreg;
    logic                 is_rd;
    logic [DATA_W-1:0]    cap;
    logic                 last_fall;

    assign last_fall = fall && (bit_cnt == '0);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (launch) nxt = pre_en ? ST_PREAMBLE : ST_FRAME;
            ST_PREAMBLE: if (last_fall) nxt = ST_FRAME;
            ST_FRAME:    if (last_fall) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            is_rd   <= 1'b0;
            cap     <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                if (launch) begin
                    shreg   <= word;
                    is_rd   <= word[RD_BIT];
                    bit_cnt <= LAST_BIT;
                    cap     <= '0;
                end
            end else begin
                if (fall) begin
                    bit_cnt <= (bit_cnt == '0) ? LAST_BIT : bit_cnt - 1'b1;
                    if (state == ST_FRAME)
                        shreg <= {shreg[FRAME_W-2:0], 1'b0};
                end
                if (rise && (state == ST_FRAME) && is_rd && (bit_cnt <= DATA_TOP))
                    cap <= {cap[DATA_W-2:0], mdio_i};
            end
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        in_pre    = (state == ST_PREAMBLE);
        mdio_o    = 1'b0;
        mdio_oe   = 1'b0;
        done      = 1'b0;
        result    = cap;
        result_rd = is_rd;
        unique case (state)
            ST_IDLE: ;
            ST_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_FRAME: begin
                mdio_o  = shreg[FRAME_W-1];
                mdio_oe = !(is_rd && (bit_cnt <= TA_IDX));
                done    = last_fall;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mdio_fc_regs.sv
module mdio_fc_regs
    import mdio_fc_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter int              DIV_W    = 7,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h128,
    parameter logic [ADDR_W-1:0] DATA_OFS = 12'h12C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wen,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    input  logic               busy,
    input  logic               done,
    input  logic [DATA_W-1:0]  result,
    input  logic               result_rd,
    output logic [31:0]        rdata,
    output logic               launch,
    output logic               pre_en,
    output logic [DIV_W-1:0]   div,
    output logic               done_flag
);
    localparam int PRE_BIT  = 7;
    localparam int DONE_BIT = 8;

    logic [31:0] data_reg;
    logic [31:0] ctrl_rd;
    logic        wr_ctrl, wr_data;

    assign wr_ctrl = wen && (addr == CTRL_OFS);
    assign wr_data = wen && (addr == DATA_OFS);
    assign launch  = wr_data && !busy && (div != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_en    <= 1'b0;
            div       <= '0;
            done_flag <= 1'b0;
            data_reg  <= '0;
        end else begin
            if (wr_ctrl) begin
                pre_en <= wdata[PRE_BIT];
                div    <= wdata[DIV_W-1:0];
            end
            if (launch) begin
                data_reg  <= wdata;
                done_flag <= 1'b0;
            end else if (done) begin
                done_flag <= 1'b1;
                if (result_rd)
                    data_reg[DATA_W-1:0] <= result;
            end
        end
    end

    always_comb begin
        ctrl_rd                = '0;
        ctrl_rd[DIV_W-1:0]     = div;
        ctrl_rd[PRE_BIT]       = pre_en;
        ctrl_rd[DONE_BIT]      = done_flag;
        if (addr == CTRL_OFS)      rdata = ctrl_rd;
        else if (addr == DATA_OFS) rdata = data_reg;
        else                       rdata = '0;
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_fc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic              launch, pre_en, done_flag;
    logic [DIV_W-1:0]  div;
    logic              busy, in_pre, done, result_rd;
    logic              rise, fall;
    logic [DATA_W-1:0] result;

    mdio_fc_regs #(
        .ADDR_W (ADDR_W),
        .DIV_W  (DIV_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (reg_wen),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .result_rd (result_rd),
        .rdata     (reg_rdata),
        .launch    (launch),
        .pre_en    (pre_en),
        .div       (div),
        .done_flag (done_flag)
    );

    mdio_fc_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_fc_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .word      (reg_wdata),
        .pre_en    (pre_en),
        .rise      (rise),
        .fall      (fall),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .in_pre    (in_pre),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .result    (result),
        .result_rd (result_rd)
    );
endmodule

// File: rtl/mdio_fc_checker.sv
module mdio_fc_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic in_pre,
    input logic launch,
    input logic done_flag,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r1_oe_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    a_r5_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
        in_pre |-> (mdio_o && mdio_oe));

    a_r3_launch_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !done_flag);

    a_r9_done_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(busy) && !busy));

    a_r6_mdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && $past(mdc)) |-> $stable(mdio_o));
endmodule

bind mdio_frame_ctrl mdio_fc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .in_pre    (in_pre),
    .launch    (launch),
    .done_flag (done_flag),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_frame_ctrl_tb.sv
module mdio_frame_ctrl_tb;
    localparam logic [11:0] CTRL = 12'h128;
    localparam logic [11:0] DATA = 12'h12C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdio_i = 1'b0;
    logic        mdc, mdio_o, mdio_oe;

    int total = 0;
    int bad = 0;

    // monitor / PHY model state
    logic        mdc_q = 1'b0;
    int          rises = 0;
    int          run_len = 0;
    int          per_err = 0;
    int          exp_half = 1;
    int          mon_p = 0;
    logic [15:0] phy_val = '0;
    logic        rec_o  [0:63];
    logic        rec_oe [0:63];

    always #2 clk = ~clk;

    mdio_frame_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdio_i    (mdio_i),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    always @(negedge clk) begin
        if (mdc && !mdc_q) begin
            if (rises < 64) begin
                rec_o[rises]  = mdio_o;
                rec_oe[rises] = mdio_oe;
            end
            if (rises > 0 && run_len != exp_half) per_err = per_err + 1;
            rises   = rises + 1;
            run_len = 1;
        end else if (!mdc && mdc_q) begin
            if (run_len != exp_half) per_err = per_err + 1;
            run_len = 1;
            begin
                int j;
                j = mon_p + 31 - rises;
                mdio_i = (j >= 0 && j <= 15) ? phy_val[j] : 1'b0;
            end
        end else begin
            run_len = run_len + 1;
        end
        mdc_q = mdc;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic run_frame(input int d, input bit pre, input logic [31:0] word,
                             input logic [15:0] pv, input bit intrude, input logic [31:0] word2);
        logic [31:0] v;
        int cyc, n;
        bit rd, ok;
        rd = word[29];
        n  = pre ? 64 : 32;
        reg_write(CTRL, {24'b0, pre, 7'(d)});
        rises = 0; per_err = 0; exp_half = d + 1; mon_p = pre ? 32 : 0; phy_val = pv;
        reg_write(DATA, word);
        cyc = 0;
        reg_read(CTRL, v);
        chk(v[8] == 1'b0, "R3 done cleared at launch", v, 32'h0);
        if (intrude) begin
            repeat (5) @(negedge clk);
            reg_write(DATA, word2);
            cyc = 7;
        end
        reg_read(CTRL, v);
        while (!v[8] && cyc < 5000) begin
            @(negedge clk);
            cyc = cyc + 1;
            reg_read(CTRL, v);
        end
        chk(cyc == 2 * n * (d + 1), "R9 completion latency", cyc, 2 * n * (d + 1));
        chk(rises == n, "R5 MDC period count", rises, n);
        chk(per_err == 0, "R4 MDC half period", per_err, 0);
        ok = 1;
        for (int k = 0; k < n - 32; k++) if (!(rec_o[k] && rec_oe[k])) ok = 0;
        chk(ok, "R5 preamble ones", 32'(ok), 1);
        ok = 1;
        for (int j = 0; j < 32; j++)
            if ((!rd || j >= 18) && rec_o[n - 1 - j] != word[j]) ok = 0;
        chk(ok, "R6 frame bits", 32'(ok), 1);
        ok = 1;
        for (int j = 0; j < 32; j++)
            if (rec_oe[n - 1 - j] != !(rd && j <= 17)) ok = 0;
        chk(ok, "R7 output enable pattern", 32'(ok), 1);
        reg_read(DATA, v);
        if (rd) chk(v == {word[31:16], pv}, "R8 read capture", v, {word[31:16], pv});
        else    chk(v == word, "R10 data register holds word", v, word);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mdc == 1'b0 && mdio_o == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset",
            {29'b0, mdc, mdio_o, mdio_oe}, 0);
        reg_read(CTRL, v); chk(v == 0, "R1 ctrl reset", v, 0);
        reg_read(DATA, v); chk(v == 0, "R1 data reset", v, 0);
        // R2 control layout
        reg_write(CTRL, 32'h0000_008A);
        reg_read(CTRL, v); chk(v == 32'h8A, "R2 ctrl readback", v, 32'h8A);
        reg_write(CTRL, 32'hFFFF_FE05);
        reg_read(CTRL, v); chk(v == 32'h05, "R2 reserved bits", v, 32'h05);
        // sweep: divisor x preamble x direction
        for (int d = 1; d <= 3; d++)
            for (int p = 0; p < 2; p++)
                for (int r = 0; r < 2; r++) begin
                    w = 32'h4002_0000 | (32'(d) << 22) | (32'(p * 5 + r) << 18);
                    if (r) w = w | 32'h2000_0000;
                    else   w = w | 32'h1000_0000 | 32'(16'h1234 * (d + p));
                    run_frame(d, p[0], w, 16'hA5C3 ^ 16'(d * 16'h1111 + p * 16'h0F0F + r), 1'b0, 32'h0);
                end
        // R10 write during busy frame
        run_frame(2, 1'b0, 32'h5016_C3C3, 16'h0, 1'b1, 32'h6FFF_FFFF);
        // R12 PHY-select frame to register 0x1F, PHY 0x15 at bit 4
        w = 32'h5000_0000 | (32'h1F << 18) | (32'h1 << 17) | (32'h15 << 4);
        run_frame(2, 1'b1, w, 16'h0, 1'b0, 32'h0);
        begin
            bit ok;
            ok = 1;
            for (int j = 18; j <= 22; j++) if (rec_o[63 - j] != 1'b1) ok = 0;
            for (int j = 4; j <= 8; j++) if (rec_o[63 - j] != w[j]) ok = 0;
            chk(ok, "R12 page select fields", 32'(ok), 1);
        end
        // R11 disabled controller ignores data writes
        reg_write(CTRL, 32'h0);
        rises = 0;
        reg_write(DATA, 32'h6123_4567);
        repeat (40) @(negedge clk);
        chk(rises == 0, "R11 no MDC when disabled", rises, 0);
        reg_read(CTRL, v); chk(v == 32'h100, "R11 done kept", v, 32'h100);
        reg_read(DATA, v); chk(v == w, "R11 data kept", v, w);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule